// File: doc/BRIEF.md
# Bus Hold Handshake Unit

This unit sits inside a bus master and lets a second master borrow the local bus. The other master raises a hold request. The unit waits until the bus cycle in progress reaches a point where it can be given up. That point is the final transfer state or an idle state. In the middle of that state, on the falling clock edge, it raises the acknowledge. In the same instant it turns off the enable that drives the address, data and control pads.

The grant lasts for as long as the request stays high. Once the request is seen low, the acknowledge falls. The pads stay floating until the core reports new work through a cycle-pending flag. The request is a plain level input with no valid/ready handshake. For requests that come from another clock domain, a parameter puts a chain of synchronizer flops on it. Setting the parameter to zero samples the request directly.

Bus state encoding on `bus_state`:
- 0 = idle
- 1 = T1
- 2 = T2
- 3 = T3
- 4 = T4
- 5 = wait

Top module: `bus_hold_unit`

## Requirements
- R1: `hold_ack` rises only while the synchronized request is high. The request reaches the decision logic after SYNC_STAGES rising edges (default 2), or directly when SYNC_STAGES is 0.
- R2: `hold_ack` rises only on a falling clock edge, and only while `bus_state` is 0 (idle) or 4 (T4). It never rises while `bus_state` is 1, 2, 3 or 5.
- R3: `bus_drive_en` goes low at the same falling edge at which `hold_ack` rises. The two are never high together.
- R4: `hold_ack` falls at the first falling edge at which the synchronized request is low.
- R5: After `hold_ack` falls, `bus_drive_en` stays low until a rising edge at which `cycle_pend` is high. It is high from that edge on.
- R6: A request that is seen during states 1, 2, 3 or 5 is kept waiting. It is granted in the following T4 (state 4) if it is still asserted there.
- R7: A request withdrawn so that the synchronized request is low by T4 is never granted.
- R8: Reset is asynchronous and active low. It forces `hold_ack` to 0 and `bus_drive_en` to 1, and clears the synchronizer. A request held high across reset must therefore pass through the synchronizer again before it is granted.
- R9: `cycle_pend` has no effect while `hold_ack` is high. The bus stays released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock. Rising edge for tracking and synchronizing, falling edge for the acknowledge |
| rst_n | input | 1 | Asynchronous active-low reset |
| hold_req | input | 1 | Active-high bus hold request from another master |
| bus_state | input | 3 | Current bus state: 0 idle, 1 T1, 2 T2, 3 T3, 4 T4, 5 wait |
| cycle_pend | input | 1 | Core has another bus cycle to run |
| hold_ack | output | 1 | Hold acknowledge to the requesting master |
| bus_drive_en | output | 1 | Enable for the address, data and control pad drivers |

## Verification
The bench targets a request that arrives early in a cycle and through wait states. A unit that grants on the request alone would raise the acknowledge in T3 or in a wait state, while its own transfer is still on the pads.

It sends a short pulse that is withdrawn before T4. This catches a unit that latches requests and grants a master that is no longer asking. It samples both before and after the falling edge of the granting T4, which exposes an acknowledge moved to the rising edge.

It also checks two release cases: the drivers must stay floating with no pending work, and a pending flag raised during the hold must be ignored. Finally, it resets during an active hold with the request still high. This exposes a synchronizer that is not cleared, or drivers left floating after reset.

// File: rtl/bh_pkg.sv
package bh_pkg;

  localparam int STATE_W = 3;

  localparam logic [STATE_W-1:0] BS_IDLE = 3'd0;
  localparam logic [STATE_W-1:0] BS_T1   = 3'd1;
  localparam logic [STATE_W-1:0] BS_T2   = 3'd2;
  localparam logic [STATE_W-1:0] BS_T3   = 3'd3;
  localparam logic [STATE_W-1:0] BS_T4   = 3'd4;
  localparam logic [STATE_W-1:0] BS_WAIT = 3'd5;

  // States in which the bus may be handed over.
  function automatic logic grant_window(input logic [STATE_W-1:0] st);
    return (st == BS_T4) || (st == BS_IDLE);
  endfunction

endpackage

// File: rtl/bh_req_sync.sv
module bh_req_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_in,
  output logic req_out
);

  generate
    if (STAGES == 0) begin : g_direct
      assign req_out = req_in;
    end else begin : g_chain
      logic [STAGES-1:0] chain_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          chain_q <= '0;
        end else begin
          for (int i = STAGES - 1; i > 0; i--) chain_q[i] <= chain_q[i-1];
          chain_q[0] <= req_in;
        end
      end
      assign req_out = chain_q[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/bh_ack_ctrl.sv
module bh_ack_ctrl
  import bh_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_s,
  input  logic [STATE_W-1:0] bus_state,
  output logic               ack
);

  logic ack_q;
  logic arm;

  assign arm = req_s && grant_window(bus_state);

  // Mid-state timing: the acknowledge moves on the falling edge only.
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_q <= 1'b0;
    end else if (ack_q) begin
      if (!req_s) ack_q <= 1'b0;
    end else if (arm) begin
      ack_q <= 1'b1;
    end
  end

  assign ack = ack_q;

  AST_ACK_RISE_WINDOW: assert property (@(negedge clk) disable iff (!rst_n)
    $rose(ack_q) |-> (bus_state == BS_T4 || bus_state == BS_IDLE)); // R2
  AST_ACK_NEEDS_REQ: assert property (@(negedge clk) disable iff (!rst_n)
    $rose(ack_q) |-> req_s); // R1
  AST_ACK_DROPS: assert property (@(negedge clk) disable iff (!rst_n)
    (ack_q && !req_s) |=> !ack_q); // R4

endmodule

// File: rtl/bh_drive_ctrl.sv
module bh_drive_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic ack,
  input  logic cycle_pend,
  output logic drive_en
);

  // Remembers that the bus was given away and is not yet reclaimed.
  logic float_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      float_q <= 1'b0;
    end else if (ack) begin
      float_q <= 1'b1;
    end else if (cycle_pend) begin
      float_q <= 1'b0;
    end
  end

  assign drive_en = !ack && !float_q;

  AST_REDRIVE_NEEDS_WORK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drive_en) |-> $past(cycle_pend)); // R5
  AST_HOLD_KEEPS_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !drive_en); // R9

endmodule

// File: rtl/bus_hold_unit.sv
module bus_hold_unit
  import bh_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               hold_req,
  input  logic [STATE_W-1:0] bus_state,
  input  logic               cycle_pend,
  output logic               hold_ack,
  output logic               bus_drive_en
);

  logic req_s;
  logic ack_w;
  logic drv_w;

  bh_req_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .req_in  (hold_req),
    .req_out (req_s)
  );

  bh_ack_ctrl i_ack (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_s     (req_s),
    .bus_state (bus_state),
    .ack       (ack_w)
  );

  bh_drive_ctrl i_drv (
    .clk        (clk),
    .rst_n      (rst_n),
    .ack        (ack_w),
    .cycle_pend (cycle_pend),
    .drive_en   (drv_w)
  );

  assign hold_ack     = ack_w;
  assign bus_drive_en = drv_w;

  AST_NO_CONTENTION_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    !(hold_ack && bus_drive_en)); // R3
  AST_NO_CONTENTION_FALL: assert property (@(negedge clk) disable iff (!rst_n)
    !(hold_ack && bus_drive_en)); // R3

endmodule

// File: tb/test_bus_hold_unit.sv
module test_bus_hold_unit;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 34;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       hold_req = 1'b0;
  logic [2:0] bus_state = 3'd0;
  logic       cycle_pend = 1'b0;
  logic       hold_ack;
  logic       bus_drive_en;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_hold_unit i_bus_hold_unit (
    .clk          (clk),
    .rst_n        (rst_n),
    .hold_req     (hold_req),
    .bus_state    (bus_state),
    .cycle_pend   (cycle_pend),
    .hold_ack     (hold_ack),
    .bus_drive_en (bus_drive_en)
  );

  // Vector layout {req, state[2:0], pend, exp_ack, exp_drv}.
  // States: 0 idle, 1 T1, 2 T2, 3 T3, 4 T4, 5 wait. Request lag: 2 cycles.
  localparam logic [6:0] VEC [NVEC] = '{
    7'b1_001_0_01, // c0 R1 not yet synced
    7'b1_010_0_01,
    7'b1_011_0_01, // R2 synced but T3
    7'b1_101_0_01, // R6 wait state: held back
    7'b1_100_0_10, // R6 granted in T4, R3 released
    7'b1_000_0_10,
    7'b0_000_0_10,
    7'b0_000_0_10,
    7'b0_000_0_00, // R4 drop, R5 still floating
    7'b0_000_0_00,
    7'b0_000_1_00,
    7'b0_001_0_01, // R5 re-driven after pend
    7'b1_000_0_01,
    7'b1_000_0_01,
    7'b1_000_0_10, // R2 granted in idle
    7'b0_000_1_10, // R9 pend during hold
    7'b0_000_1_10,
    7'b0_000_1_00,
    7'b0_000_1_01,
    7'b1_001_0_01, // R7 short pulse
    7'b0_010_0_01,
    7'b0_011_0_01,
    7'b0_100_0_01, // R7 no grant in T4
    7'b0_000_0_01,
    7'b1_001_0_01,
    7'b1_010_0_01,
    7'b1_011_0_01,
    7'b1_100_0_10, // R6
    7'b0_000_0_10,
    7'b0_000_0_10,
    7'b0_000_0_00,
    7'b0_000_0_00, // R5 no work: stays floating
    7'b0_000_1_00,
    7'b0_000_0_01
  };

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0b expected=%0b t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic cyc(input logic r, input logic [2:0] st, input logic p);
    @(posedge clk);
    #1;
    hold_req = r; bus_state = st; cycle_pend = p;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #3;
    chk("R8 reset ack", hold_ack, 1'b0);
    chk("R8 reset drive", bus_drive_en, 1'b1);
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (2) cyc(1'b0, 3'd0, 1'b0);

    for (int k = 0; k < NVEC; k++) begin
      cyc(VEC[k][6], VEC[k][5:3], VEC[k][2]);
      #7;
      chk($sformatf("vec%0d ack", k), hold_ack, VEC[k][1]);
      chk($sformatf("vec%0d drive", k), bus_drive_en, VEC[k][0]);
    end

    // R2 R6: long wait phase, then grant at the falling edge of T4.
    for (int k = 0; k < 6; k++) begin
      cyc(1'b1, 3'd5, 1'b0);
      #7 chk("R2 wait state no ack", hold_ack, 1'b0);
    end
    cyc(1'b1, 3'd4, 1'b0);
    #2 chk("R2 before falling edge", hold_ack, 1'b0);
    chk("R3 driven before grant", bus_drive_en, 1'b1);
    #5 chk("R2 after falling edge", hold_ack, 1'b1);
    chk("R3 released with grant", bus_drive_en, 1'b0);

    // R8: reset during a hold with the request kept high.
    cyc(1'b1, 3'd0, 1'b0);
    #1 rst_n = 1'b0;
    #1 chk("R8 async ack clear", hold_ack, 1'b0);
    chk("R8 async drive on", bus_drive_en, 1'b1);
    @(posedge clk);
    #1 rst_n = 1'b1;
    #7 chk("R8 resync stage1", hold_ack, 1'b0);
    @(posedge clk);
    #8 chk("R8 resync stage2", hold_ack, 1'b0);
    @(posedge clk);
    #8 chk("R8 granted after resync", hold_ack, 1'b1);
    chk("R8 released after resync", bus_drive_en, 1'b0);

    cyc(1'b0, 3'd0, 1'b1);
    repeat (3) cyc(1'b0, 3'd0, 1'b1);
    #7 chk("R5 final re-drive", bus_drive_en, 1'b1);
    chk("R4 final ack low", hold_ack, 1'b0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule